// File: doc/BRIEF.md
# Precision-Time Event Timestamp Capture Unit

This per-port block records the value of a free-running time counter at the moment a precision-time event message starts, in either direction. An upstream parser supplies the message type, the transport-specific nibble and the sequence identifier, together with a one-cycle frame-start strobe for each direction. The block decides whether the message qualifies. It then stores the time and the sequence identifier in one of three capture slots: two for received frames and one for transmitted frames.

Software reaches the block through a small 16-bit register port. A select line picks between the shared registers and this port's registers. Shared registers hold a per-type enable mask and a per-type slot-routing mask. The port's configuration word can disable capture, forbid overwriting of a pending capture, and set the expected transport-specific value. Each slot reports a valid flag and a code telling whether a pending capture was replaced or a new event was dropped. Software acknowledges a slot by writing zero to its status word.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset the port configuration word reads 0x0001 (capture disabled), the enable and routing masks read 0x0000, the shared tag register reads 0x88F7, and every slot word reads 0x0000.
- R2: An event qualifies only if its message type is below 4 and the enable-mask bit of that type is set (bit0 type 0 Sync, bit1 type 1 Delay_Req, bit2 type 2 Pdelay_Req, bit3 type 3 Pdelay_Resp). Configuration bit0 set blocks capture in both directions.
- R3: With configuration bit11 clear, an event qualifies only if its transport-specific nibble equals configuration bits [15:12]. With bit11 set, the nibble is not compared.
- R4: A qualifying received event goes to arrival slot 1 if the routing-mask bit of its type is set, otherwise to arrival slot 0. A qualifying transmitted event goes to the departure slot. Received and transmitted events in the same cycle are both captured.
- R5: The time input is sampled on the clock edge that sees the strobe, and the slot is valid after that edge. A register read returns data one cycle after the address is presented.
- R6: A capture into a slot whose valid flag is clear sets status to 0x0001 (bit0 valid, bits [2:1] code 0). It also stores time bits [15:0], time bits [31:16] and the sequence identifier.
- R7: A capture into a still-valid slot with overwrite allowed (configuration bit1 clear) stores the new time and sequence and sets the code to 1, so the status word reads 0x0003.
- R8: A capture into a still-valid slot with configuration bit1 set keeps the old time and sequence and sets the code to 2, so the status word reads 0x0005.
- R9: Writing zero to a slot's status word clears valid and code. A nonzero write to a status word, or any write to a time or sequence word, has no effect.
- R10: With the select line high, addresses 0x00, 0x01 and 0x02 are the tag, enable mask and routing mask. With it low, 0x00 is configuration, and slots sit at 0x08 (arrival 0), 0x0C (arrival 1) and 0x10 (departure), as status, time low, time high, sequence. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_cnt | input | 32 | Free-running time counter |
| rx_sof | input | 1 | Receive frame-start strobe |
| rx_msg_type | input | 4 | Receive message type |
| rx_tspec | input | 4 | Receive transport-specific nibble |
| rx_seq_id | input | 16 | Receive sequence identifier |
| tx_sof | input | 1 | Transmit frame-start strobe |
| tx_msg_type | input | 4 | Transmit message type |
| tx_tspec | input | 4 | Transmit transport-specific nibble |
| tx_seq_id | input | 16 | Transmit sequence identifier |
| reg_global | input | 1 | 1 selects shared registers, 0 port registers |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 32-bit time value split over two words, four event types and three slots. These settings bring every slot word, both halves of the time value and the full type range into reach. The type range includes type values at or above four, which alias onto mask bits if the range check is lost. Each capture scenario is followed by register reads whose expected words the driver queues in advance, covering overwrite, discard, clear and simultaneous-direction cases.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL      = 2'd0,
    ST_OVERWRITTEN = 2'd1,
    ST_DISCARDED   = 2'd2
  } slot_code_e;

  localparam logic [4:0] G_TAG     = 5'h00;
  localparam logic [4:0] G_EN      = 5'h01;
  localparam logic [4:0] G_PTR     = 5'h02;
  localparam logic [4:0] P_CFG     = 5'h00;
  localparam int         SLOT_BASE = 8;
  localparam int         SLOT_WORDS = 4;
  localparam logic [15:0] TAG_RESET = 16'h88F7;
  localparam logic [15:0] CFG_RESET = 16'h0001;

  localparam int CFG_DIS_BIT  = 0;
  localparam int CFG_NOOVR_BIT = 1;
  localparam int CFG_TSIGN_BIT = 11;
  localparam int CFG_TSEXP_LSB = 12;
endpackage

// File: rtl/ts_event_filter.sv
module ts_event_filter #(
  parameter int MSG_W  = 4,
  parameter int TS_W   = 4,
  parameter int N_EVT  = 4
) (
  input  logic             sof,
  input  logic [MSG_W-1:0] msg_type,
  input  logic [TS_W-1:0]  tspec,
  input  logic [N_EVT-1:0] en_mask,
  input  logic [N_EVT-1:0] ptr_mask,
  input  logic             port_dis,
  input  logic             tspec_ign,
  input  logic [TS_W-1:0]  tspec_exp,
  output logic             hit,
  output logic             to_alt
);
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1;

  logic             is_evt;
  logic [IDX_W-1:0] idx;
  logic             ts_ok;

  always_comb begin
    is_evt = (msg_type < MSG_W'(N_EVT));
    idx    = msg_type[IDX_W-1:0];
    ts_ok  = tspec_ign || (tspec == tspec_exp);
    hit    = sof && !port_dis && is_evt && en_mask[idx] && ts_ok;
    to_alt = is_evt && ptr_mask[idx];
  end
endmodule

// File: rtl/ts_slot.sv
module ts_slot
  import ts_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              ovr_dis,
  input  logic              clr,
  input  logic [TIME_W-1:0] time_in,
  input  logic [SEQ_W-1:0]  seq_in,
  output logic              valid,
  output slot_code_e        code,
  output logic [TIME_W-1:0] time_q,
  output logic [SEQ_W-1:0]  seq_q
);
  logic live;

  always_comb live = valid && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      code   <= ST_NORMAL;
      time_q <= '0;
      seq_q  <= '0;
    end else if (hit) begin
      if (!live) begin
        valid  <= 1'b1;
        code   <= ST_NORMAL;
        time_q <= time_in;
        seq_q  <= seq_in;
      end else if (!ovr_dis) begin
        code   <= ST_OVERWRITTEN;
        time_q <= time_in;
        seq_q  <= seq_in;
      end else begin
        code   <= ST_DISCARDED;
      end
    end else if (clr) begin
      valid <= 1'b0;
      code  <= ST_NORMAL;
    end
  end

  // R6: any accepted event leaves the slot valid
  p_valid_after_hit_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> valid);
  // R7: replacing a pending capture reports code 1 and takes new data
  p_overwrite_code_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && valid && !clr && !ovr_dis) |=> (code == ST_OVERWRITTEN && seq_q == $past(seq_in)));
  // R8: a dropped event leaves the stored time untouched
  p_keep_on_discard_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && valid && !clr && ovr_dis) |=> ($stable(time_q) && $stable(seq_q) && code == ST_DISCARDED));
  // R9: an acknowledge with no new event empties the slot
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> (!valid && code == ST_NORMAL));
  // R5: stored data only moves on an accepted event
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(time_q) && $stable(seq_q)));
endmodule

// File: rtl/ts_regs.sv
module ts_regs
  import ts_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int N_EVT  = 4,
  parameter int N_SLOT = 3,
  parameter int TIME_W = 2 * DATA_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_global,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_wr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic [N_SLOT-1:0]              s_valid,
  input  logic [N_SLOT-1:0][1:0]         s_code,
  input  logic [N_SLOT-1:0][TIME_W-1:0]  s_time,
  input  logic [N_SLOT-1:0][DATA_W-1:0]  s_seq,
  output logic [N_SLOT-1:0]              s_clr,
  output logic [N_EVT-1:0]               en_mask,
  output logic [N_EVT-1:0]               ptr_mask,
  output logic [DATA_W-1:0]              port_cfg
);
  localparam int WSEL_W = (SLOT_WORDS > 1) ? $clog2(SLOT_WORDS) : 1;

  logic [DATA_W-1:0] tag_q;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] rd_next;
  logic              wr_g;
  logic              wr_p;

  always_comb begin
    wr_g = reg_wr && reg_global;
    wr_p = reg_wr && !reg_global;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= DATA_W'(TAG_RESET);
      en_q  <= '0;
      ptr_q <= '0;
      cfg_q <= DATA_W'(CFG_RESET);
    end else begin
      if (wr_g && reg_addr == ADDR_W'(G_TAG)) tag_q <= reg_wdata;
      if (wr_g && reg_addr == ADDR_W'(G_EN))  en_q  <= reg_wdata;
      if (wr_g && reg_addr == ADDR_W'(G_PTR)) ptr_q <= reg_wdata;
      if (wr_p && reg_addr == ADDR_W'(P_CFG)) cfg_q <= reg_wdata;
    end
  end

  always_comb begin
    en_mask  = en_q[N_EVT-1:0];
    ptr_mask = ptr_q[N_EVT-1:0];
    port_cfg = cfg_q;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_SLOT; gi++) begin : g_clr
      localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(SLOT_BASE + gi * SLOT_WORDS);
      always_comb s_clr[gi] = wr_p && (reg_addr == STS_ADDR) && (reg_wdata == '0);
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (reg_global) begin
      case (reg_addr)
        ADDR_W'(G_TAG): rd_next = tag_q;
        ADDR_W'(G_EN):  rd_next = en_q;
        ADDR_W'(G_PTR): rd_next = ptr_q;
        default:        rd_next = '0;
      endcase
    end else if (reg_addr == ADDR_W'(P_CFG)) begin
      rd_next = cfg_q;
    end else begin
      for (int i = 0; i < N_SLOT; i++) begin
        if (reg_addr[ADDR_W-1:WSEL_W] == (ADDR_W-WSEL_W)'((SLOT_BASE + i * SLOT_WORDS) / SLOT_WORDS)) begin
          case (reg_addr[WSEL_W-1:0])
            2'd0:    rd_next = {{(DATA_W-3){1'b0}}, s_code[i], s_valid[i]};
            2'd1:    rd_next = s_time[i][DATA_W-1:0];
            2'd2:    rd_next = s_time[i][TIME_W-1:DATA_W];
            default: rd_next = s_seq[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R9: an acknowledge only ever comes from a zero write to port space
  p_clr_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (|s_clr) |-> (reg_wr && !reg_global && reg_wdata == '0));
  // R9: at most one slot is acknowledged per write
  p_clr_single_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_clr));
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TIME_W = 32,
  parameter int ADDR_W = 5,
  parameter int MSG_W  = 4,
  parameter int TS_W   = 4,
  parameter int N_EVT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_cnt,
  input  logic              rx_sof,
  input  logic [MSG_W-1:0]  rx_msg_type,
  input  logic [TS_W-1:0]   rx_tspec,
  input  logic [DATA_W-1:0] rx_seq_id,
  input  logic              tx_sof,
  input  logic [MSG_W-1:0]  tx_msg_type,
  input  logic [TS_W-1:0]   tx_tspec,
  input  logic [DATA_W-1:0] tx_seq_id,
  input  logic              reg_global,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int N_SLOT = 3;
  localparam int S_ARR0 = 0;
  localparam int S_ARR1 = 1;
  localparam int S_DEP  = 2;

  logic [N_SLOT-1:0]             s_valid;
  logic [N_SLOT-1:0][1:0]        s_code;
  logic [N_SLOT-1:0][TIME_W-1:0] s_time;
  logic [N_SLOT-1:0][DATA_W-1:0] s_seq;
  logic [N_SLOT-1:0]             s_clr;
  logic [N_SLOT-1:0]             s_hit;
  logic [N_SLOT-1:0][DATA_W-1:0] s_seq_in;
  logic [N_EVT-1:0]              en_mask;
  logic [N_EVT-1:0]              ptr_mask;
  logic [DATA_W-1:0]             port_cfg;
  logic                          rx_hit, rx_alt, tx_hit, tx_alt_unused;
  logic                          port_dis;

  always_comb port_dis = port_cfg[CFG_DIS_BIT];

  ts_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_EVT(N_EVT), .N_SLOT(N_SLOT), .TIME_W(TIME_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_global(reg_global), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_valid(s_valid), .s_code(s_code), .s_time(s_time), .s_seq(s_seq),
    .s_clr(s_clr), .en_mask(en_mask), .ptr_mask(ptr_mask), .port_cfg(port_cfg)
  );

  ts_event_filter #(.MSG_W(MSG_W), .TS_W(TS_W), .N_EVT(N_EVT)) u_rx_filt (
    .sof(rx_sof), .msg_type(rx_msg_type), .tspec(rx_tspec),
    .en_mask(en_mask), .ptr_mask(ptr_mask), .port_dis(port_dis),
    .tspec_ign(port_cfg[CFG_TSIGN_BIT]), .tspec_exp(port_cfg[CFG_TSEXP_LSB +: TS_W]),
    .hit(rx_hit), .to_alt(rx_alt)
  );

  ts_event_filter #(.MSG_W(MSG_W), .TS_W(TS_W), .N_EVT(N_EVT)) u_tx_filt (
    .sof(tx_sof), .msg_type(tx_msg_type), .tspec(tx_tspec),
    .en_mask(en_mask), .ptr_mask(ptr_mask), .port_dis(port_dis),
    .tspec_ign(port_cfg[CFG_TSIGN_BIT]), .tspec_exp(port_cfg[CFG_TSEXP_LSB +: TS_W]),
    .hit(tx_hit), .to_alt(tx_alt_unused)
  );

  always_comb begin
    s_hit[S_ARR0]    = rx_hit && !rx_alt;
    s_hit[S_ARR1]    = rx_hit &&  rx_alt;
    s_hit[S_DEP]     = tx_hit;
    s_seq_in[S_ARR0] = rx_seq_id;
    s_seq_in[S_ARR1] = rx_seq_id;
    s_seq_in[S_DEP]  = tx_seq_id;
  end

  genvar gs;
  generate
    for (gs = 0; gs < N_SLOT; gs++) begin : g_slot
      slot_code_e code_w;
      ts_slot #(.TIME_W(TIME_W), .SEQ_W(DATA_W)) u_slot (
        .clk(clk), .rst(rst),
        .hit(s_hit[gs]), .ovr_dis(port_cfg[CFG_NOOVR_BIT]), .clr(s_clr[gs]),
        .time_in(time_cnt), .seq_in(s_seq_in[gs]),
        .valid(s_valid[gs]), .code(code_w), .time_q(s_time[gs]), .seq_q(s_seq[gs])
      );
      always_comb s_code[gs] = code_w;
    end
  endgenerate

  // R2: a disabled port never records an event
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    port_dis |=> ($stable(s_seq) && $stable(s_time)));
  // R4: a received event lands in exactly one arrival slot
  p_route_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_hit[S_ARR1:S_ARR0]));
  // R4: the departure slot only reacts to the transmit strobe
  p_dep_from_tx_r4: assert property (@(posedge clk) disable iff (rst)
    s_hit[S_DEP] |-> tx_sof);
endmodule

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] time_cnt = '0;
  logic        rx_sof = 1'b0, tx_sof = 1'b0;
  logic [3:0]  rx_msg_type = '0, tx_msg_type = '0;
  logic [3:0]  rx_tspec = '0, tx_tspec = '0;
  logic [15:0] rx_seq_id = '0, tx_seq_id = '0;
  logic        reg_global = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_capture_unit u_dut (
    .clk(clk), .rst(rst), .time_cnt(time_cnt),
    .rx_sof(rx_sof), .rx_msg_type(rx_msg_type), .rx_tspec(rx_tspec), .rx_seq_id(rx_seq_id),
    .tx_sof(tx_sof), .tx_msg_type(tx_msg_type), .tx_tspec(tx_tspec), .tx_seq_id(tx_seq_id),
    .reg_global(reg_global), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  int  n_cmp = 0;
  int  n_bad = 0;
  logic rd_req = 1'b0;
  logic resp_due = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) resp_due <= rd_req;

  // monitor: pops the expected word and compares it with the registered read data
  always @(negedge clk) begin
    if (resp_due && exp_q.size() > 0) begin
      exp_item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %04h expected %04h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic g, input logic [4:0] a, input logic [15:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    reg_global = g; reg_addr = a; rd_req = 1'b1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic g, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_global = g; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ev(input bit do_rx, input bit do_tx, input logic [3:0] ty,
                    input logic [3:0] ts, input logic [15:0] rseq,
                    input logic [15:0] tseq, input logic [31:0] t);
    @(negedge clk);
    time_cnt = t;
    rx_sof = do_rx; rx_msg_type = ty; rx_tspec = ts; rx_seq_id = rseq;
    tx_sof = do_tx; tx_msg_type = ty; tx_tspec = ts; tx_seq_id = tseq;
    @(negedge clk);
    rx_sof = 1'b0; tx_sof = 1'b0;
    time_cnt = t + 32'd1000;
  endtask

  task automatic slot4(input logic [4:0] base, input logic [15:0] st, input logic [15:0] lo,
                       input logic [15:0] hi, input logic [15:0] sq, input string tag);
    rd(1'b0, base,        st, {tag, " status"});
    rd(1'b0, base + 5'd1, lo, {tag, " time lo"});
    rd(1'b0, base + 5'd2, hi, {tag, " time hi"});
    rd(1'b0, base + 5'd3, sq, {tag, " seq"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(1'b0, 5'h00, 16'h0001, "R1 cfg reset");
    rd(1'b1, 5'h00, 16'h88F7, "R1 tag reset");
    rd(1'b1, 5'h01, 16'h0000, "R1 enable reset");
    rd(1'b1, 5'h02, 16'h0000, "R1 route reset");
    rd(1'b0, 5'h08, 16'h0000, "R1 arr0 reset");
    rd(1'b0, 5'h10, 16'h0000, "R1 dep reset");

    wr(1'b1, 5'h01, 16'h000F);
    wr(1'b1, 5'h02, 16'h0008);
    wr(1'b0, 5'h00, 16'h0800);
    rd(1'b1, 5'h02, 16'h0008, "R10 route readback");

    // R6 R5 capture into empty arrival 0
    ev(1, 0, 4'd0, 4'd1, 16'h1234, 16'h0, 32'hAABB_CCDD);
    slot4(5'h08, 16'h0001, 16'hCCDD, 16'hAABB, 16'h1234, "R6 arr0");
    rd(1'b0, 5'h0C, 16'h0000, "R4 arr1 untouched");

    // R4 Pdelay_Resp routed to arrival 1
    ev(1, 0, 4'd3, 4'd0, 16'h0042, 16'h0, 32'h1111_2222);
    slot4(5'h0C, 16'h0001, 16'h2222, 16'h1111, 16'h0042, "R4 arr1");

    // R7 overwrite
    ev(1, 0, 4'd0, 4'd0, 16'h5678, 16'h0, 32'h0102_0304);
    slot4(5'h08, 16'h0003, 16'h0304, 16'h0102, 16'h5678, "R7 arr0");

    // R9 ignored writes, then clear
    wr(1'b0, 5'h0C, 16'h0005);
    rd(1'b0, 5'h0C, 16'h0001, "R9 nonzero status write");
    wr(1'b0, 5'h0D, 16'hFFFF);
    rd(1'b0, 5'h0D, 16'h2222, "R9 time word write");
    wr(1'b0, 5'h08, 16'h0000);
    rd(1'b0, 5'h08, 16'h0000, "R9 clear arr0");

    // R8 overwrite disabled
    wr(1'b0, 5'h00, 16'h0802);
    ev(1, 0, 4'd1, 4'd0, 16'h0A0A, 16'h0, 32'h0000_0010);
    rd(1'b0, 5'h08, 16'h0001, "R8 first capture");
    ev(1, 0, 4'd2, 4'd0, 16'h0B0B, 16'h0, 32'h0000_0020);
    slot4(5'h08, 16'h0005, 16'h0010, 16'h0000, 16'h0A0A, "R8 arr0");

    // R2 port disable blocks both directions
    wr(1'b0, 5'h08, 16'h0000);
    wr(1'b0, 5'h0C, 16'h0000);
    wr(1'b0, 5'h00, 16'h0801);
    ev(1, 1, 4'd0, 4'd0, 16'h0C0C, 16'h0D0D, 32'h0000_0030);
    rd(1'b0, 5'h08, 16'h0000, "R2 disabled rx");
    rd(1'b0, 5'h10, 16'h0000, "R2 disabled tx");

    // R2 enable mask and type range
    wr(1'b0, 5'h00, 16'h0800);
    wr(1'b1, 5'h01, 16'h0001);
    ev(1, 0, 4'd1, 4'd0, 16'h0E0E, 16'h0, 32'h0000_0040);
    rd(1'b0, 5'h08, 16'h0000, "R2 masked type");
    wr(1'b1, 5'h01, 16'h000F);
    ev(1, 0, 4'd5, 4'd0, 16'h0F0F, 16'h0, 32'h0000_0050);
    rd(1'b0, 5'h08, 16'h0000, "R2 non-event type");

    // R3 transport-specific compare
    wr(1'b0, 5'h00, 16'h1000);
    ev(1, 0, 4'd0, 4'd0, 16'h1111, 16'h0, 32'h0000_0060);
    rd(1'b0, 5'h08, 16'h0000, "R3 mismatch dropped");
    ev(1, 0, 4'd0, 4'd1, 16'h7777, 16'h0, 32'hDEAD_0001);
    slot4(5'h08, 16'h0001, 16'h0001, 16'hDEAD, 16'h7777, "R3 match");

    // R4 simultaneous rx and tx
    wr(1'b0, 5'h00, 16'h0800);
    wr(1'b0, 5'h08, 16'h0000);
    ev(1, 1, 4'd1, 4'd1, 16'h0101, 16'h0202, 32'h0000_BEEF);
    slot4(5'h08, 16'h0001, 16'hBEEF, 16'h0000, 16'h0101, "R4 both arr0");
    slot4(5'h10, 16'h0001, 16'hBEEF, 16'h0000, 16'h0202, "R4 both dep");

    // R10 unmapped addresses
    rd(1'b0, 5'h05, 16'h0000, "R10 port hole");
    rd(1'b1, 5'h03, 16'h0000, "R10 global hole");
    rd(1'b0, 5'h14, 16'h0000, "R10 past slots");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule